// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block watches twenty-four external interrupt lines and turns them into six interrupt requests for a downstream interrupt controller. Every line passes through a two-flop synchroniser. It is then judged against its own trigger mode: low level, high level, falling edge, rising edge, or both edges. A qualifying event sets a sticky pending flag for that line.

Software reaches the block through a small 32-bit register bus. It programs the per-line trigger fields, the mask bits and the pending flags over this bus. A pending flag is cleared by writing a one to its bit. Each pending flag is gated by the line's mask bit to form the line's active request.

Lines 0 to 3 each own a parent output. Lines 4 to 7 share one parent, and lines 8 to 23 share another. A build-time parameter can route lines 0 to 3 straight from their synchronisers to their parents instead. In that build those four parents ignore the pending and mask bits.

Top module: `xint_ctrl`

## Requirements
- R1: After reset every trigger register reads 0 and the mask register reads 0x00FFFFFF. With all lines masked, every parent output is low.
- R2: The register map uses byte addresses. Trigger register k sits at 0x88 + 4*k and holds lines 8k to 8k+7, with line n's 4-bit code at bits [4*(n mod 8)+3 : 4*(n mod 8)]. The mask register sits at 0xA4 and the pending register at 0xA8, with bit n belonging to line n in both. Any other address reads 0. Read data appears on the clock edge that samples the read strobe.
- R3: Code 4 triggers on a rising edge, code 2 on a falling edge and code 6 on either edge. A line change driven before clock edge k sets the pending flag at edge k+2, and the flag is not yet set after edge k+1.
- R4: Code 0 means level low and code 1 means level high. While the level is active, the pending flag is set again on every cycle, so a clear only takes effect once the input has gone inactive.
- R5: Writing a one to a bit of the pending register clears that flag, and writing a zero leaves it unchanged. Without a clearing write, a set flag stays set.
- R6: Codes 3, 5 and 7 to 15 are disabled: a line with such a code never sets its pending flag.
- R7: Parent 4 is high when any of lines 4 to 7 is pending and unmasked. Parent 5 does the same for lines 8 to 23.
- R8: In the default build, parent i (i from 0 to 3) is high exactly when line i is pending and unmasked.
- R9: In the bypass build, parent i (i from 0 to 3) follows the synchronised level of line i two clock edges after the line changes, whatever the mask and pending state.
- R10: A masked line still latches its pending flag. Clearing its mask bit then raises the parent at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 8 | Byte address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| extLines | input | 24 | Asynchronous external interrupt lines |
| parentIrq | output | 6 | Requests: bits 0-3 direct, bit 4 lines 4-7, bit 5 lines 8-23 |

## Verification
The main test sweeps every line through each of the three edge codes, with only that line unmasked. The rising and falling halves of each pulse show which edge each code reacts to, and the parent that rises shows which group the line falls into. The pending readback shows which bit the event lands on. Separate level-high and level-low pulses, with a clear written while the level is held, show that a level re-arms its flag where an edge would not. A masked-then-unmasked pulse shows the mask gates only the output. A second instance built for bypass is driven with all sixteen patterns on lines 0 to 3 to show those parents follow the pins directly.

// File: rtl/xint_pkg.sv
package xint_pkg;
  localparam int CFG_IDX_W = 2;

  localparam logic [3:0] TRIG_LOW  = 4'd0;
  localparam logic [3:0] TRIG_HIGH = 4'd1;
  localparam logic [3:0] TRIG_FALL = 4'd2;
  localparam logic [3:0] TRIG_RISE = 4'd4;
  localparam logic [3:0] TRIG_BOTH = 4'd6;

  typedef enum logic [1:0] {RD_NONE, RD_CFG, RD_MASK, RD_PEND} rdSrc_e;

  typedef struct packed {
    logic                 cfgWe;
    logic [CFG_IDX_W-1:0] cfgIdx;
    logic                 maskWe;
    logic                 pendClr;
    rdSrc_e               rdSrc;
  } busStrobe_t;
endpackage

// File: rtl/xint_decode.sv
module xint_decode
  import xint_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_CFG_REGS = 3,
  parameter logic [ADDR_W-1:0] CFG_BASE = 8'h88,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'hA4,
  parameter logic [ADDR_W-1:0] PEND_ADDR = 8'hA8
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output busStrobe_t        strobe
);
  localparam logic [ADDR_W-1:0] CFG_END = ADDR_W'(CFG_BASE + 4 * NUM_CFG_REGS);

  logic cfgHit;
  logic [ADDR_W-1:0] cfgOffs;

  always_comb begin
    cfgOffs = addr - CFG_BASE;
    cfgHit  = (addr >= CFG_BASE) && (addr < CFG_END) && (addr[1:0] == 2'b00);

    strobe.cfgIdx  = cfgOffs[CFG_IDX_W+1:2];
    strobe.cfgWe   = wrEn && cfgHit;
    strobe.maskWe  = wrEn && (addr == MASK_ADDR);
    strobe.pendClr = wrEn && (addr == PEND_ADDR);

    if (cfgHit)                 strobe.rdSrc = RD_CFG;
    else if (addr == MASK_ADDR) strobe.rdSrc = RD_MASK;
    else if (addr == PEND_ADDR) strobe.rdSrc = RD_PEND;
    else                        strobe.rdSrc = RD_NONE;
  end
endmodule

// File: rtl/xint_line.sv
module xint_line
  import xint_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lineIn,
  input  logic [3:0] trigCode,
  output logic       syncOut,
  output logic       setOut
);
  logic [2:0] shReg;
  logic curLvl, prevLvl;

  always_ff @(posedge clk) begin
    if (rst) shReg <= '0;
    else     shReg <= {shReg[1:0], lineIn};
  end

  assign curLvl  = shReg[1];
  assign prevLvl = shReg[2];
  assign syncOut = curLvl;

  always_comb begin
    case (trigCode)
      TRIG_LOW:  setOut = ~curLvl;
      TRIG_HIGH: setOut = curLvl;
      TRIG_FALL: setOut = prevLvl & ~curLvl;
      TRIG_RISE: setOut = curLvl & ~prevLvl;
      TRIG_BOTH: setOut = curLvl ^ prevLvl;
      default:   setOut = 1'b0;
    endcase
  end
endmodule

// File: rtl/xint_core.sv
module xint_core
  import xint_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter int DATA_W = 32,
  parameter int FIELD_W = 4,
  parameter int LINES_PER_REG = 8,
  parameter int NUM_DIRECT = 4,
  parameter int SHARED_SPLIT = 8,
  parameter bit DIRECT_BYPASS = 1'b0,
  localparam int NUM_CFG_REGS = (NUM_LINES + LINES_PER_REG - 1) / LINES_PER_REG,
  localparam int NUM_PARENTS = NUM_DIRECT + 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  busStrobe_t             strobe,
  input  logic                   rdEn,
  input  logic [DATA_W-1:0]      wrData,
  output logic [DATA_W-1:0]      rdData,
  input  logic [NUM_LINES-1:0]   lineIn,
  output logic [NUM_PARENTS-1:0] parentIrq
);
  logic [DATA_W-1:0]    cfgReg [NUM_CFG_REGS];
  logic [NUM_LINES-1:0] maskReg, pendReg, setVec, syncVec, activeVec, clrVec;
  logic [DATA_W-1:0]    rdCfg;

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    localparam int R = n / LINES_PER_REG;
    localparam int S = (n % LINES_PER_REG) * FIELD_W;
    xint_line u_line (
      .clk      (clk),
      .rst      (rst),
      .lineIn   (lineIn[n]),
      .trigCode (cfgReg[R][S +: FIELD_W]),
      .syncOut  (syncVec[n]),
      .setOut   (setVec[n])
    );
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < NUM_CFG_REGS; r++) begin
      if (rst) cfgReg[r] <= '0;
      else if (strobe.cfgWe && strobe.cfgIdx == CFG_IDX_W'(r)) cfgReg[r] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                maskReg <= '1;
    else if (strobe.maskWe) maskReg <= wrData[NUM_LINES-1:0];
  end

  assign clrVec = strobe.pendClr ? wrData[NUM_LINES-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) pendReg <= '0;
    else     pendReg <= (pendReg & ~clrVec) | setVec;
  end

  assign activeVec = pendReg & ~maskReg;

  for (genvar i = 0; i < NUM_DIRECT; i++) begin : g_direct
    if (DIRECT_BYPASS) begin : g_byp
      assign parentIrq[i] = syncVec[i];
    end else begin : g_reg
      assign parentIrq[i] = activeVec[i];
    end
  end
  assign parentIrq[NUM_DIRECT]   = |activeVec[SHARED_SPLIT-1:NUM_DIRECT];
  assign parentIrq[NUM_DIRECT+1] = |activeVec[NUM_LINES-1:SHARED_SPLIT];

  always_comb begin
    rdCfg = '0;
    for (int r = 0; r < NUM_CFG_REGS; r++)
      if (strobe.cfgIdx == CFG_IDX_W'(r)) rdCfg = cfgReg[r];
  end

  always_ff @(posedge clk) begin
    if (rst) rdData <= '0;
    else if (rdEn) begin
      case (strobe.rdSrc)
        RD_CFG:  rdData <= rdCfg;
        RD_MASK: rdData <= DATA_W'(maskReg);
        RD_PEND: rdData <= DATA_W'(pendReg);
        default: rdData <= '0;
      endcase
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> ((&maskReg) && (pendReg == '0))); // R1

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
    !strobe.pendClr |=> (($past(pendReg) & ~pendReg) == '0)); // R5

  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (rst)
    strobe.pendClr |=> ((pendReg & $past(wrData[NUM_LINES-1:0] & ~setVec)) == '0)); // R5

  AST_SHARED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (&maskReg[NUM_LINES-1:SHARED_SPLIT]) |-> !parentIrq[NUM_DIRECT+1]); // R7
endmodule

// File: rtl/xint_ctrl.sv
module xint_ctrl
  import xint_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NUM_DIRECT = 4,
  parameter int SHARED_SPLIT = 8,
  parameter bit DIRECT_BYPASS = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  busWrEn,
  input  logic                  busRdEn,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [DATA_W-1:0]     busWrData,
  output logic [DATA_W-1:0]     busRdData,
  input  logic [NUM_LINES-1:0]  extLines,
  output logic [NUM_DIRECT+1:0] parentIrq
);
  localparam int LINES_PER_REG = DATA_W / 4;
  localparam int NUM_CFG_REGS = (NUM_LINES + LINES_PER_REG - 1) / LINES_PER_REG;

  busStrobe_t strobe;

  xint_decode #(
    .ADDR_W       (ADDR_W),
    .NUM_CFG_REGS (NUM_CFG_REGS)
  ) u_decode (
    .wrEn   (busWrEn),
    .addr   (busAddr),
    .strobe (strobe)
  );

  xint_core #(
    .NUM_LINES     (NUM_LINES),
    .DATA_W        (DATA_W),
    .FIELD_W       (4),
    .LINES_PER_REG (LINES_PER_REG),
    .NUM_DIRECT    (NUM_DIRECT),
    .SHARED_SPLIT  (SHARED_SPLIT),
    .DIRECT_BYPASS (DIRECT_BYPASS)
  ) u_core (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .rdEn      (busRdEn),
    .wrData    (busWrData),
    .rdData    (busRdData),
    .lineIn    (extLines),
    .parentIrq (parentIrq)
  );
endmodule

// File: tb/xint_ctrl_test.sv
module xint_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wrData = '0, rdData;
  logic [23:0] lines = '0;
  logic [5:0] parent;
  logic [23:0] bLines = '0;
  logic [31:0] bRdData;
  logic [5:0] bParent;
  int total = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xint_ctrl uut (
    .clk(clk), .rst(rst), .busWrEn(wrEn), .busRdEn(rdEn), .busAddr(addr),
    .busWrData(wrData), .busRdData(rdData), .extLines(lines), .parentIrq(parent)
  );

  xint_ctrl #(.DIRECT_BYPASS(1'b1)) uutBypass (
    .clk(clk), .rst(rst), .busWrEn(1'b0), .busRdEn(1'b0), .busAddr(8'h00),
    .busWrData(32'h0), .busRdData(bRdData), .extLines(bLines), .parentIrq(bParent)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [7:0] a, logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(logic [7:0] a, output logic [31:0] d);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    d = rdData; rdEn = 1'b0;
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setCfg(logic [31:0] c0, logic [31:0] c1, logic [31:0] c2);
    busWrite(8'h88, c0); busWrite(8'h8C, c1); busWrite(8'h90, c2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [3:0] code;
    int pIdx;
    waitCyc(3);
    rst = 1'b0;
    waitCyc(4);

    // R1 reset state
    busRead(8'h88, rd); chk("R1 cfg0", rd, 32'h0);
    busRead(8'h8C, rd); chk("R1 cfg1", rd, 32'h0);
    busRead(8'h90, rd); chk("R1 cfg2", rd, 32'h0);
    busRead(8'hA4, rd); chk("R1 mask", rd, 32'h00FFFFFF);
    chk("R1 parents", {26'h0, parent}, 32'h0);
    // R4 reset code 0 is level low, all lines low
    busRead(8'hA8, rd); chk("R4 level-low pend", rd, 32'h00FFFFFF);
    busRead(8'hA0, rd); chk("R2 unmapped", rd, 32'h0);

    // R6 all disabled
    setCfg(32'h77777777, 32'h35F9A7B3, 32'hCDE57777);
    busRead(8'h8C, rd); chk("R2 cfg1 readback", rd, 32'h35F9A7B3);
    setCfg(32'h77777777, 32'h77777777, 32'h77777777);
    busWrite(8'hA8, 32'h00FFFFFF);
    busRead(8'hA8, rd); chk("R5 clear all", rd, 32'h0);
    lines = 24'hFFFFFF; waitCyc(4);
    lines = 24'h000000; waitCyc(4);
    busRead(8'hA8, rd); chk("R6 disabled codes", rd, 32'h0);

    // R3 R7 R8 edge sweep over every line
    for (int ln = 0; ln < 24; ln++) begin
      for (int m = 0; m < 3; m++) begin
        logic [31:0] c [3];
        code = (m == 0) ? 4'd4 : (m == 1) ? 4'd2 : 4'd6;
        pIdx = (ln < 4) ? ln : (ln < 8) ? 4 : 5;
        for (int r = 0; r < 3; r++) c[r] = 32'h77777777;
        c[ln / 8][(ln % 8) * 4 +: 4] = code;
        setCfg(c[0], c[1], c[2]);
        busWrite(8'hA4, ~(32'h1 << ln) & 32'h00FFFFFF);
        busWrite(8'hA8, 32'h00FFFFFF);
        chk("R6 idle parents", {26'h0, parent}, 32'h0);
        lines[ln] = 1'b1;
        waitCyc(2);
        if (m == 0) chk("R3 latency early", {26'h0, parent}, 32'h0);
        waitCyc(1);
        chk((ln < 4) ? "R8 rise" : "R3 R7 rise", {26'h0, parent},
            (m != 1) ? (32'h1 << pIdx) : 32'h0);
        if (m != 1) begin
          busRead(8'hA8, rd); chk("R2 pend bit", rd, 32'h1 << ln);
          busWrite(8'hA8, 32'h1 << ln);
          chk("R5 w1c edge", {26'h0, parent}, 32'h0);
        end
        lines[ln] = 1'b0;
        waitCyc(3);
        chk("R3 fall", {26'h0, parent}, (m != 0) ? (32'h1 << pIdx) : 32'h0);
        busWrite(8'hA8, 32'h00FFFFFF);
      end
    end

    // R4 level high on line 9
    setCfg(32'h77777777, 32'h77777717, 32'h77777777);
    busWrite(8'hA4, ~(32'h1 << 9) & 32'h00FFFFFF);
    busWrite(8'hA8, 32'h00FFFFFF);
    lines[9] = 1'b1; waitCyc(3);
    chk("R4 high set", {26'h0, parent}, 32'h20);
    busWrite(8'hA8, 32'h1 << 9);
    chk("R4 high clear ignored", {26'h0, parent}, 32'h20);
    lines[9] = 1'b0; waitCyc(3);
    busWrite(8'hA8, 32'h1 << 9);
    chk("R4 high cleared", {26'h0, parent}, 32'h0);

    // R4 level low on line 2
    setCfg(32'h77777077, 32'h77777777, 32'h77777777);
    busWrite(8'hA4, ~(32'h1 << 2) & 32'h00FFFFFF);
    waitCyc(1);
    chk("R4 low set", {26'h0, parent}, 32'h4);
    busWrite(8'hA8, 32'h4);
    chk("R4 low clear ignored", {26'h0, parent}, 32'h4);
    lines[2] = 1'b1; waitCyc(3);
    busWrite(8'hA8, 32'h4);
    chk("R4 low cleared", {26'h0, parent}, 32'h0);
    lines[2] = 1'b0;

    // R10 masked latch, line 5 rising
    setCfg(32'h77477777, 32'h77777777, 32'h77777777);
    busWrite(8'hA4, 32'h00FFFFFF);
    busWrite(8'hA8, 32'h00FFFFFF);
    lines[5] = 1'b1; waitCyc(3);
    chk("R10 masked quiet", {26'h0, parent}, 32'h0);
    busRead(8'hA8, rd); chk("R10 masked latched", rd, 32'h20);
    busWrite(8'hA8, 32'h0);
    busRead(8'hA8, rd); chk("R5 zero write", rd, 32'h20);
    busWrite(8'hA4, ~(32'h1 << 5) & 32'h00FFFFFF);
    chk("R10 R7 unmask", {26'h0, parent}, 32'h10);
    lines[5] = 1'b0;

    // R9 bypass build
    for (int p = 0; p < 16; p++) begin
      bLines[3:0] = 4'(p);
      waitCyc(2);
      chk("R9 bypass", {26'h0, bParent}, 32'(p));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule